// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Sequencer

This block sits between a synchronous request port and an external byte-wide asynchronous static RAM with 19 address bits. A single request carries a direction flag, an address and, for stores, a data byte. The block turns each request into a sequence of chip-select, write-enable and output-enable levels. Every phase is a whole number of system clocks, so the analog limits of the memory's speed grade are met. Writes are timed by the write-enable strobe. Output enable stays high for the whole of a write, and the block's data drivers turn on only after a turnaround period long enough for the memory's outputs to reach high impedance.

The data pad is split into an output byte, an output-enable and an input byte; the board-level tri-state buffer is built outside the block. Phase lengths are parameters in clocks: each one is the timing limit divided by the clock period, rounded up. The defaults suit a 10 ns clock and the slower speed grade. States: IDLE (waiting for a request), RD_ACC (chip select and output enable low during the access count), WR_TURN (chip select low, drivers off, turnaround), WR_PULSE (write enable low, drivers on), WR_HOLD (write enable high, drivers still on for data hold) and RECOV (chip select high, recovery and padding to the minimum cycle). The transitions are:
- IDLE to RD_ACC on a read request, and IDLE to WR_TURN on a write request.
- RD_ACC to RECOV after ACC_CYC clocks, capturing the read byte on the last clock.
- WR_TURN to WR_PULSE after TURN_CYC clocks.
- WR_PULSE to WR_HOLD after WE_CYC clocks.
- WR_HOLD to RECOV after one clock.
- RECOV to IDLE when its count ends, with ready high on its last clock.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset and while idle, mem_cs_n, mem_we_n and mem_oe_n are 1, mem_dq_oe is 0 and ready is 0. Whenever mem_cs_n is 1, mem_we_n and mem_oe_n are 1 and mem_dq_oe is 0.
- R2: A read accepted in IDLE (req=1, we=0) holds mem_cs_n=0, mem_oe_n=0 and mem_we_n=1, with mem_dq_oe=0, for exactly ACC_CYC clocks starting in the clock after acceptance.
- R3: rdata takes the mem_dq_i value sampled at the edge that ends the last access clock. It holds that value until the next read.
- R4: A write accepted in IDLE (req=1, we=1) runs three phases with mem_cs_n=0. First come TURN_CYC clocks with mem_we_n=1 and mem_dq_oe=0. Then come WE_CYC clocks with mem_we_n=0 and mem_dq_oe=1. Then comes one clock with mem_we_n=1 and mem_dq_oe=1.
- R5: mem_oe_n stays 1 throughout every write.
- R6: ready is 1 for exactly one clock, the last clock of recovery, and mem_cs_n is 1 in that clock.
- R7: A read's recovery lasts max(TURN_CYC, CYC_MIN-ACC_CYC, 1) clocks. A write's recovery lasts max(1, CYC_MIN-(TURN_CYC+WE_CYC+1)) clocks. A request held high after ready is accepted in the following IDLE clock.
- R8: addr and wdata are latched at acceptance, and mem_addr and mem_dq_o hold those values for the whole cycle. Changes on addr, wdata or req during a cycle have no effect.
- R9: A byte written to an address reads back unchanged, and the memory's timing limits for write pulse, data setup, address setup and access time are met.
- R10: mem_dq_oe is never 1 while mem_oe_n is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Request, sampled in IDLE |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 19 | Request address |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Captured read byte |
| ready | output | 1 | One-clock completion pulse |
| mem_addr | output | 19 | Memory address bus |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_o | output | 8 | Byte driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for the data pad |
| mem_dq_i | input | 8 | Byte returned from the memory |

## Verification
The hardest case to reach is a request that arrives while the block is still in recovery. The request must wait for IDLE, and the request port must keep its values until then, while the previous cycle's address and data stay on the memory pins. The stimulus keeps req high right after ready, so reads and writes run back to back. It also changes addr and wdata halfway through each cycle. A behavioural memory then checks that the scrambled values never reach the pins and that turnaround and minimum cycle spacing still hold.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_ACC,
        S_WR_TURN,
        S_WR_PULSE,
        S_WR_HOLD,
        S_RECOV
    } sram_state_e;
endpackage

// File: rtl/sram_step_cnt.sv
module sram_step_cnt #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/sram_io_regs.sv
module sram_io_regs #(
    parameter int AW = 19,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          capture,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] wdata_in,
    input  logic [DW-1:0] dq_in,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] wdata_q,
    output logic [DW-1:0] rdata_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= addr_in;
            wdata_q <= wdata_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (capture)
            rdata_q <= dq_in;
    end
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W   = 19,
    parameter int DATA_W   = 8,
    parameter int ACC_CYC  = 7,
    parameter int WE_CYC   = 5,
    parameter int TURN_CYC = 3,
    parameter int CYC_MIN  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);
    localparam int RD_GAP  = (TURN_CYC > CYC_MIN - ACC_CYC) ? TURN_CYC : CYC_MIN - ACC_CYC;
    localparam int RD_REC  = (RD_GAP < 1) ? 1 : RD_GAP;
    localparam int WR_USED = TURN_CYC + WE_CYC + 1;
    localparam int WR_REC  = (CYC_MIN > WR_USED) ? CYC_MIN - WR_USED : 1;
    localparam int M1      = (ACC_CYC > WE_CYC) ? ACC_CYC : WE_CYC;
    localparam int M2      = (TURN_CYC > RD_REC) ? TURN_CYC : RD_REC;
    localparam int M3      = (M1 > M2) ? M1 : M2;
    localparam int CNT_MAX = (M3 > WR_REC) ? M3 : WR_REC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    sram_state_e      state, nxt;
    logic             load, accept, capture, zero;
    logic [CNT_W-1:0] load_val;

    sram_step_cnt #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .zero     (zero)
    );

    sram_io_regs #(.AW(ADDR_W), .DW(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .capture  (capture),
        .addr_in  (addr),
        .wdata_in (wdata),
        .dq_in    (mem_dq_i),
        .addr_q   (mem_addr),
        .wdata_q  (mem_dq_o),
        .rdata_q  (rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= S_IDLE;
        else
            state <= nxt;
    end

    always_comb begin
        nxt      = state;
        load     = 1'b0;
        load_val = '0;
        accept   = 1'b0;
        capture  = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (req) begin
                    accept = 1'b1;
                    load   = 1'b1;
                    if (we) begin
                        nxt      = S_WR_TURN;
                        load_val = CNT_W'(TURN_CYC - 1);
                    end else begin
                        nxt      = S_RD_ACC;
                        load_val = CNT_W'(ACC_CYC - 1);
                    end
                end
            end
            S_RD_ACC: begin
                if (zero) begin
                    capture  = 1'b1;
                    nxt      = S_RECOV;
                    load     = 1'b1;
                    load_val = CNT_W'(RD_REC - 1);
                end
            end
            S_WR_TURN: begin
                if (zero) begin
                    nxt      = S_WR_PULSE;
                    load     = 1'b1;
                    load_val = CNT_W'(WE_CYC - 1);
                end
            end
            S_WR_PULSE: begin
                if (zero)
                    nxt = S_WR_HOLD;
            end
            S_WR_HOLD: begin
                nxt      = S_RECOV;
                load     = 1'b1;
                load_val = CNT_W'(WR_REC - 1);
            end
            S_RECOV: begin
                if (zero)
                    nxt = S_IDLE;
            end
            default: nxt = S_IDLE;
        endcase
    end

    always_comb begin
        mem_cs_n  = 1'b1;
        mem_we_n  = 1'b1;
        mem_oe_n  = 1'b1;
        mem_dq_oe = 1'b0;
        ready     = 1'b0;
        unique case (state)
            S_IDLE: ;
            S_RD_ACC: begin
                mem_cs_n = 1'b0;
                mem_oe_n = 1'b0;
            end
            S_WR_TURN: mem_cs_n = 1'b0;
            S_WR_PULSE: begin
                mem_cs_n  = 1'b0;
                mem_we_n  = 1'b0;
                mem_dq_oe = 1'b1;
            end
            S_WR_HOLD: begin
                mem_cs_n  = 1'b0;
                mem_dq_oe = 1'b1;
            end
            S_RECOV: ready = zero;
            default: ;
        endcase
    end
endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk #(
    parameter int ADDR_W = 19
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_cs_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_dq_oe,
    input logic              ready,
    input logic [ADDR_W-1:0] mem_addr
);
    a_r1_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cs_n |-> (mem_we_n && mem_oe_n && !mem_dq_oe));

    a_r4_drive_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && !mem_we_n) |-> mem_dq_oe);

    a_r5_oe_off_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

    a_r6_ready_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> mem_cs_n);

    a_r6_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);

    a_r8_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && !$past(mem_cs_n)) |-> $stable(mem_addr));

    a_r10_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);
endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_cs_n  (mem_cs_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_oe (mem_dq_oe),
    .ready     (ready),
    .mem_addr  (mem_addr)
);

// File: tb/test_sram_async_ctrl.sv
module test_sram_async_ctrl;
    localparam int PER  = 20;
    localparam int ACC  = 4;
    localparam int WEC  = 3;
    localparam int TRN  = 2;
    localparam int CMIN = 4;
    localparam int T_ACC = 70, T_WP = 50, T_DW = 30, T_AW = 60, T_HZ = 25, T_RC = 70;
    localparam int RREC = (TRN > CMIN - ACC) ? TRN : ((CMIN - ACC) < 1 ? 1 : CMIN - ACC);
    localparam int WREC = (CMIN > TRN + WEC + 1) ? CMIN - (TRN + WEC + 1) : 1;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        req = 1'b0, we = 1'b0;
    logic [18:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata, mem_dq_o;
    logic [7:0]  mem_dq_i = 8'h5A;
    logic        ready, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [18:0] mem_addr;

    int n_cmp = 0, n_bad = 0, cycles = 0;

    sram_async_ctrl #(.ACC_CYC(ACC), .WE_CYC(WEC), .TURN_CYC(TRN), .CYC_MIN(CMIN)) i_sram_async_ctrl (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ready(ready), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_o(mem_dq_o),
        .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    always #(PER/2) clk = ~clk;

    function automatic logic [7:0] init_val(input logic [18:0] a);
        return a[7:0] ^ {1'b0, a[18:12]} ^ 8'h3C;
    endfunction

    task automatic check(input bit ok, input string req_tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req_tag, act, exp, $time);
        end
    endtask

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // reference model: expected {cs_n,we_n,oe_n,dq_oe,ready} per clock
    logic [4:0]  exp_q[$];
    logic [18:0] cur_addr;
    logic [7:0]  cur_data, cur_rd;
    bit          cur_is_rd;
    logic [7:0]  shadow[int];

    task automatic push_n(input logic [4:0] v, input int n);
        for (int i = 0; i < n; i++) exp_q.push_back(v);
    endtask

    always @(negedge clk) begin
        logic [4:0] e;
        bit was_empty;
        was_empty = (exp_q.size() == 0);
        e = was_empty ? 5'b11100 : exp_q.pop_front();
        // R1 R2 R4 R6 R7 strobe sequence
        check({mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, ready} == e,
              "R1/R2/R4/R6/R7 strobes", {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, ready}, e);
        if (!e[4]) check(mem_addr == cur_addr, "R8 address held", mem_addr, cur_addr);
        if (e[1])  check(mem_dq_o == cur_data, "R8 write data held", mem_dq_o, cur_data);
        if (e[0] && cur_is_rd) check(rdata == cur_rd, "R3 R9 read data", rdata, cur_rd);
        if (was_empty && req && rst_n) begin
            cur_addr  = addr;
            cur_data  = wdata;
            cur_is_rd = !we;
            if (we) begin
                shadow[int'(addr)] = wdata;
                push_n(5'b01100, TRN);
                push_n(5'b00110, WEC);
                push_n(5'b01110, 1);
                push_n(5'b11100, WREC - 1);
            end else begin
                cur_rd = shadow.exists(int'(addr)) ? shadow[int'(addr)] : init_val(addr);
                push_n(5'b01000, ACC);
                push_n(5'b11100, RREC - 1);
            end
            push_n(5'b11101, 1);
        end
    end

    // behavioural memory with timing checks
    logic [7:0]  cells[int];
    int rd_run = 0, hiz_run = 100, we_run = 0, dat_run = 0, adr_run = 0, since_cs = 100;
    logic [7:0]  prev_dq = '0, w_data = '0;
    logic [18:0] prev_addr = '0, w_addr = '0;
    bit prev_wr = 0, prev_cs = 1;
    int w_we = 0, w_dat = 0, w_adr = 0;

    always @(negedge clk) begin
        bit rd_mode, wr_act;
        rd_mode = !mem_cs_n && !mem_oe_n && mem_we_n;
        wr_act  = !mem_cs_n && !mem_we_n;
        rd_run  = rd_mode ? rd_run + 1 : 0;
        hiz_run = rd_mode ? 0 : hiz_run + 1;
        adr_run = (mem_addr == prev_addr) ? adr_run + 1 : 1;
        dat_run = (mem_dq_oe && mem_dq_o == prev_dq) ? dat_run + 1 : (mem_dq_oe ? 1 : 0);
        we_run  = wr_act ? we_run + 1 : 0;
        since_cs++;
        if (prev_cs && !mem_cs_n) begin
            check(since_cs * PER >= T_RC, "R7 cycle spacing", since_cs * PER, T_RC);
            since_cs = 0;
        end
        if (mem_dq_oe)
            check(hiz_run * PER >= T_HZ, "R10 bus turnaround", hiz_run * PER, T_HZ);
        if (wr_act) begin
            w_we = we_run; w_dat = dat_run; w_adr = adr_run;
            w_addr = mem_addr; w_data = mem_dq_o;
            check(mem_oe_n, "R5 oe high in write", mem_oe_n, 1);
        end
        if (prev_wr && !wr_act) begin
            check(w_we * PER >= T_WP,  "R9 write pulse", w_we * PER, T_WP);
            check(w_dat * PER >= T_DW, "R9 data setup", w_dat * PER, T_DW);
            check(w_adr * PER >= T_AW, "R9 address setup", w_adr * PER, T_AW);
            cells[int'(w_addr)] = w_data;
        end
        if (rd_mode && rd_run * PER >= T_ACC)
            mem_dq_i <= cells.exists(int'(mem_addr)) ? cells[int'(mem_addr)] : init_val(mem_addr);
        else
            mem_dq_i <= 8'h5A;
        prev_wr = wr_act; prev_cs = mem_cs_n;
        prev_addr = mem_addr; prev_dq = mem_dq_o;
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            report();
        end
    end

    task automatic issue(input bit w, input logic [18:0] a, input logic [7:0] d);
        int k = 0;
        @(posedge clk); #1;
        req = 1'b1; we = w; addr = a; wdata = d;
        do begin
            @(negedge clk);
            k++;
            if (k == 3) begin  // R8: changes mid-cycle must be ignored
                addr  = ~a;
                wdata = ~d;
                we    = ~w;
            end
        end while (!ready);
    endtask

    task automatic release_req();
        @(posedge clk); #1;
        req = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(rdata == 8'h00, "R1 reset rdata", rdata, 0);
        issue(0, 19'h00010, 8'h00); release_req();         // R2 R3 unwritten read
        repeat (4) @(posedge clk);
        issue(1, 19'h00000, 8'hA7); release_req();         // R4 R5 lowest address
        issue(0, 19'h00000, 8'h00); release_req();         // R9 readback
        issue(1, 19'h7FFFF, 8'hFF);                        // R7 back-to-back
        issue(1, 19'h12345, 8'h00);
        issue(0, 19'h7FFFF, 8'h00);
        issue(0, 19'h12345, 8'h00);
        issue(1, 19'h12345, 8'h3C);
        issue(0, 19'h12345, 8'h00); release_req();
        repeat (5) @(posedge clk);
        issue(0, 19'h00010, 8'h00); release_req();         // R3 R9 repeat read
        repeat (5) @(negedge clk);
        check(mem_cs_n && !mem_dq_oe, "R1 idle after run", {mem_cs_n, mem_dq_oe}, 2'b10);
        report();
    end
endmodule